// File: doc/BRIEF.md
# Serial-Keyed Program Memory Loader

This block gives test equipment a way to read and write a 2048-byte on-chip program store through a few shared pins. The reset pin doubles as a serial input. After a device reset, the reset pin is released low and then carries a ten-bit unlock key, one bit per clock, least significant bit first. If the key matches the built-in value, the block enters a sticky programming state. If it does not match, the block stays in normal operation until the next reset.

In the programming state, an address-select pin steers one 8-bit address port. With the select low, the port loads the low address byte. With the select high, it loads the top three address bits. A mode pin chooses between verify and program. In verify, the block drives the addressed byte onto the data port. In program, the data port is an input, and a falling edge of the mode pin writes the byte to the addressed location.

Top module: `nvm_keyed_loader`

## Requirements
- R1: A device reset happens only after `rst_in` is sampled high on RST_CLKS consecutive rising clock edges (default 24, two machine cycles of 12 clocks). The reset clears `prog_mode` and `data_oe` and sets the latched address to 0. A shorter high pulse resets nothing.
- R2: After a reset, the edge that first samples `rst_in` low is the release edge. The ten edges that follow sample the key bits, least significant bit first. If the ten bits equal KEY (default 10'h2CD), `prog_mode` is 1 from the tenth key edge onward.
- R3: If the ten key bits do not match, `prog_mode` stays 0 until the next reset, whatever `rst_in` carries afterwards.
- R4: In the programming state, when `addr_sel` is 0 on two successive edges, the second edge loads `addr_port` into address bits 7..0.
- R5: In the programming state, when `addr_sel` is 1 on two successive edges, the second edge loads `addr_port` bits 2..0 into address bits 10..8. Port bits 7..3 are ignored.
- R6: An edge where `addr_sel` differs from its value at the previous edge loads nothing.
- R7: In the programming state with `vfy_mode` = 1, `data_oe` is 1 and `data_out` shows the byte at the current address in the same cycle.
- R8: In the programming state, an edge that samples `vfy_mode` = 0 after sampling 1 on the previous edge writes `data_in` to the current address. While `vfy_mode` is 0, `data_oe` is 0.
- R9: Outside the programming state, `data_oe` stays 0 and `data_out` stays 0. The address pins, the select pin, the mode pin and the data pins change neither the address nor the memory.
- R10: The memory contents survive a device reset. A write is visible to verify at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock; also strobes the serial key |
| rst_in | input | 1 | Reset pin and serial key input |
| addr_sel | input | 1 | 0: port loads low address byte, 1: port loads upper address bits |
| vfy_mode | input | 1 | 1: verify, 0: program |
| addr_port | input | 8 | Shared address port |
| data_in | input | 8 | Write data in program mode |
| data_out | output | 8 | Addressed byte in verify mode, 0 otherwise |
| data_oe | output | 1 | Drive enable for the data port |
| prog_mode | output | 1 | Sticky programming-state flag |

## Verification
A key shifter that slips by one bit either rejects the correct key or accepts a wrong one. That shows on `prog_mode` at the tenth key edge, the same cycle the key completes. A wrong address latch, or a wrong select-stability check, shows on `data_out` at the first verify cycle after the load. A misplaced write strobe shows as a stale or corrupted byte when that location is next verified, possibly after a reset. The reference model predicts `prog_mode`, `data_oe` and every known `data_out` byte on every clock.

// File: rtl/nvm_loader_pkg.sv
package nvm_loader_pkg;

  typedef enum logic [1:0] {
    PS_SHIFT  = 2'd0,
    PS_PROG   = 2'd1,
    PS_NORMAL = 2'd2
  } ld_state_t;

  // An edge sampling 1 then 0
  function automatic logic fell(input logic prev, input logic now);
    return prev & ~now;
  endfunction

endpackage

// File: rtl/rst_filter.sv
module rst_filter #(
  parameter int RST_CLKS = 24
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_active
);
  localparam int CW = $clog2(RST_CLKS + 1);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_in)                         hi_cnt <= '0;
    else if (hi_cnt != CW'(RST_CLKS))    hi_cnt <= hi_cnt + 1'b1;
  end

  assign rst_active = (hi_cnt == CW'(RST_CLKS));

  // R1
  short_pulse_chk: assert property (@(posedge clk) !rst_in |=> !rst_active);
endmodule

// File: rtl/key_shifter.sv
module key_shifter #(
  parameter int          KEY_W = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h2CD
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic done,
  output logic match
);
  localparam int NW = $clog2(KEY_W + 1);

  logic [KEY_W-1:0] sh;
  logic [NW-1:0]    nbits;
  logic [KEY_W-1:0] sh_next;

  assign sh_next = {bit_in, sh[KEY_W-1:1]};
  assign done    = en && (nbits == NW'(KEY_W - 1));
  assign match   = (sh_next == KEY);

  always_ff @(posedge clk) begin
    if (clr) begin
      sh    <= '0;
      nbits <= '0;
    end else if (en) begin
      sh    <= sh_next;
      nbits <= nbits + 1'b1;
    end
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int ADDR_W = 11,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  input  logic              sel,
  input  logic [PORT_W-1:0] port,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - PORT_W;

  logic [PORT_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              sel_q;
  logic              sel_steady;

  assign sel_steady = (sel == sel_q);
  assign addr       = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (clr) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel;
      if (en && sel_steady) begin
        if (sel) hi_q <= port[HI_W-1:0];
        else     lo_q <= port;
      end
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(addr));
  // R6
  sel_change_chk: assert property (@(posedge clk) disable iff (clr)
    (sel != sel_q) |=> $stable(addr));
endmodule

// File: rtl/prog_array.sv
module prog_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  // R8
  write_lands_chk: assert property (@(posedge clk)
    wr_en |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/nvm_keyed_loader.sv
module nvm_keyed_loader
  import nvm_loader_pkg::*;
#(
  parameter int               ADDR_W     = 11,
  parameter int               DATA_W     = 8,
  parameter int               PORT_W     = 8,
  parameter int               KEY_W      = 10,
  parameter logic [KEY_W-1:0] KEY        = 10'h2CD,
  parameter int               CLK_PER_MC = 12,
  parameter int               RST_MC     = 2
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              addr_sel,
  input  logic              vfy_mode,
  input  logic [PORT_W-1:0] addr_port,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              prog_mode
);
  localparam int RST_CLKS = CLK_PER_MC * RST_MC;

  ld_state_t         state;
  logic              rst_active;
  logic              key_done, key_match;
  logic              mode_q;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdata;

  rst_filter #(.RST_CLKS(RST_CLKS)) u_rst (
    .clk(clk), .rst_in(rst_in), .rst_active(rst_active)
  );

  key_shifter #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .clk(clk), .clr(rst_active), .en(state == PS_SHIFT),
    .bit_in(rst_in), .done(key_done), .match(key_match)
  );

  addr_latch #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_addr (
    .clk(clk), .clr(rst_active), .en(state == PS_PROG),
    .sel(addr_sel), .port(addr_port), .addr(addr)
  );

  prog_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wdata(data_in), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst_active) begin
      state  <= PS_SHIFT;
      mode_q <= 1'b0;
    end else begin
      mode_q <= vfy_mode;
      if (state == PS_SHIFT && key_done)
        state <= key_match ? PS_PROG : PS_NORMAL;
    end
  end

  assign prog_mode = (state == PS_PROG);
  assign wr_en     = prog_mode && fell(mode_q, vfy_mode);
  assign data_oe   = prog_mode && vfy_mode;
  assign data_out  = data_oe ? rdata : '0;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst_active |=> !prog_mode);
  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (rst_active)
    (key_done && key_match) |=> prog_mode);
  // R3
  lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst_active)
    (state == PS_NORMAL) |=> (state == PS_NORMAL));
  // R8
  no_drive_prog_chk: assert property (@(posedge clk) disable iff (rst_active)
    wr_en |-> !data_oe);
endmodule

// File: tb/nvm_keyed_loader_tb.sv
module nvm_keyed_loader_tb;
  localparam int          RST = 24;
  localparam logic [9:0]  KEY = 10'h2CD;

  logic       clk = 1'b0;
  logic       rst_in = 1'b0, addr_sel = 1'b0, vfy_mode = 1'b0;
  logic [7:0] addr_port = '0, data_in = '0;
  logic [7:0] data_out;
  logic       data_oe, prog_mode;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nvm_keyed_loader u_dut (
    .clk(clk), .rst_in(rst_in), .addr_sel(addr_sel), .vfy_mode(vfy_mode),
    .addr_port(addr_port), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .prog_mode(prog_mode)
  );

  // Behavioural reference model
  int         hi_run = 0;
  int         m_state = 0;   // 0 shift, 1 prog, 2 normal
  bit         q_bits[$];
  int         m_lo = 0, m_hi = 0;
  bit         m_sel_q = 0, m_mode_q = 0;
  logic [7:0] m_mem [int];
  bit         armed = 0;

  always @(posedge clk) begin
    if (hi_run >= RST) begin
      armed = 1; m_state = 0; q_bits.delete();
      m_lo = 0; m_hi = 0; m_sel_q = 0; m_mode_q = 0;
    end else begin
      int a_old;
      a_old = m_hi * 256 + m_lo;
      if (m_state == 0) begin
        q_bits.push_back(rst_in);
        if (q_bits.size() == 10) begin
          int v;
          v = 0;
          foreach (q_bits[i]) if (q_bits[i]) v += (1 << i);
          m_state = (v == int'(KEY)) ? 1 : 2;
        end
      end else if (m_state == 1) begin
        if (addr_sel == m_sel_q) begin
          if (addr_sel) m_hi = addr_port % 8;
          else          m_lo = addr_port;
        end
        if (m_mode_q && !vfy_mode) m_mem[a_old] = data_in;
      end
      m_sel_q  = addr_sel;
      m_mode_q = vfy_mode;
    end
    hi_run = rst_in ? ((hi_run < RST) ? hi_run + 1 : RST) : 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: sample outputs after the edge, compare with the model
  task automatic step();
    @(posedge clk);
    #2;
    if (armed) begin
      bit eo;
      int a;
      eo = (m_state == 1) && vfy_mode;
      a  = m_hi * 256 + m_lo;
      chk("R2/R3 prog_mode", prog_mode, (m_state == 1));
      chk("R7/R8/R9 data_oe", data_oe, eo);
      if (!eo) chk("R9 data_out idle", data_out, 0);
      else if (m_mem.exists(a)) chk("R7 data_out", data_out, m_mem[a]);
    end
  endtask

  task automatic do_reset();
    rst_in = 1'b1;
    repeat (RST + 2) step();
    rst_in = 1'b0;
    step();               // release edge
  endtask

  task automatic send_key(input logic [9:0] k);
    for (int i = 0; i < 10; i++) begin
      rst_in = k[i];
      step();
    end
    rst_in = 1'b0;
  endtask

  task automatic load_addr(input int a);
    addr_sel = 1'b0; addr_port = 8'(a % 256); step(); step();
    addr_sel = 1'b1; addr_port = 8'hF8 | 8'(a / 256); step(); step();
  endtask

  task automatic write_byte(input int a, input logic [7:0] d);
    load_addr(a);
    vfy_mode = 1'b1; step();
    data_in = d; vfy_mode = 1'b0; step();
    data_in = ~d; step();
    vfy_mode = 1'b1; step();
  endtask

  initial begin
    rst_in = 1'b0;
    step();
    do_reset();
    // R1 reset state
    chk("R1 prog_mode after reset", prog_mode, 0);
    chk("R1 data_oe after reset", data_oe, 0);

    // R3: wrong key, then correct bits and pin activity ignored
    send_key(KEY ^ 10'h001);
    chk("R3 wrong key rejected", prog_mode, 0);
    send_key(KEY);
    chk("R3 stays locked", prog_mode, 0);
    vfy_mode = 1'b1; addr_port = 8'h12; step(); step();
    chk("R9 no drive when locked", data_oe, 0);
    vfy_mode = 1'b0; data_in = 8'h66; step();
    vfy_mode = 1'b1; step();
    chk("R9 no drive when locked", data_out, 0);

    // R2: correct key unlocks
    do_reset();
    vfy_mode = 1'b1;
    send_key(KEY);
    chk("R2 key unlocks", prog_mode, 1);

    // R4/R5/R8/R7 writes at boundaries and middle
    write_byte(11'h000, 8'hA7);
    chk("R8 R10 write 0x000", data_out, 8'hA7);
    write_byte(11'h7FF, 8'h3C);
    chk("R5 R8 write 0x7FF", data_out, 8'h3C);
    write_byte(11'h534, 8'h5A);
    chk("R4 R5 write 0x534", data_out, 8'h5A);
    load_addr(11'h000);
    chk("R7 verify 0x000", data_out, 8'hA7);
    load_addr(11'h7FF);
    chk("R7 verify 0x7FF", data_out, 8'h3C);
    chk("R7 data_oe in verify", data_oe, 1);

    // R6: one-cycle select swap loads nothing
    load_addr(11'h534);
    addr_sel = 1'b0; addr_port = 8'h10; step();
    addr_sel = 1'b1; addr_port = 8'h00; step();
    chk("R6 unstable select ignored", data_out, 8'h5A);

    // R8: data_oe low in program mode
    vfy_mode = 1'b0; step();
    chk("R8 no drive in program", data_oe, 0);
    vfy_mode = 1'b1; step();

    // R1: short high pulse does not reset
    rst_in = 1'b1; repeat (5) step(); rst_in = 1'b0; step();
    chk("R1 short pulse ignored", prog_mode, 1);

    // R9/R10: locked-state write attempt, then contents survive reset
    do_reset();
    send_key(KEY ^ 10'h200);
    vfy_mode = 1'b1; step();
    data_in = 8'hEE; vfy_mode = 1'b0; step(); step();
    do_reset();
    vfy_mode = 1'b1;
    send_key(KEY);
    step();
    chk("R9 R10 addr 0 kept after locked write and reset", data_out, 8'hA7);
    chk("R1 address reset to 0 verified", data_oe, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule